// File: doc/BRIEF.md
# UART Interrupt Request Unit

This block turns the event strobes, status levels and FIFO count of a UART into one interrupt request line and a code naming the most urgent pending cause. It tracks six causes: hold register empty, transmission complete, receive data available, receive time-out, line status (sticky receive error flags) and modem status change. The serial shifters, the FIFO storage, baud generation and register decoding sit outside. This block sees them only as strobes (register reads and writes, FIFO pushes and pops, bit ticks), as a FIFO occupancy count, and as per-byte error flags.

Every cause has a pending bit that is held whether or not it is enabled. A five-bit enable vector selects which pending causes drive the request line and the identification code. The receive time-out is measured in bit-clock ticks, with one character counted as a parameter number of ticks. In nine-bit mode a parity mismatch marks an address byte and does not count as a parity error.

Top module: `uart_irq_unit`

## Requirements
- R1: While reset is held, `irq` is 0, `intId` is 0 and `lineStatus` is 0. All pending causes are clear when reset is released.
- R2: The cycle after `thrEmpty` changes from 0 to 1 sets hold-empty pending. This cause is enabled by `intEnable[1]` and reports code 4.
- R3: A `txShiftDone` strobe sets transmission-complete pending. This cause is enabled by `intEnable[4]` and reports code 5. A `thrWrite` clears both transmit causes, and it wins over a set that arrives in the same cycle.
- R4: Data-available pending follows the FIFO count one cycle later. With `fifoEn`=1 it is set when the count is nonzero and at least `trigLevel`. With `fifoEn`=0 it is set when the count is nonzero. The cause is enabled by `intEnable[0]` and reports code 2.
- R5: With `fifoEn`=1 and the count between 1 and `trigLevel`-1, `bitTick` pulses are counted while no FIFO push or pop occurs. The cycle after the CHAR_TICKS*TO_CHARS-th such tick, time-out pending is set. It shares `intEnable[0]` and reports code 3. After one tick fewer, it is still clear.
- R6: Once set, time-out pending stays set through pops and through the count rising to or above the trigger. It clears only in the cycle after the count is observed at zero.
- R7: A FIFO push (`rxWrite`) or pop (`rxRead`) restarts the tick count from zero.
- R8: `lineStatus` holds sticky flags. Bit 0 is parity error, bit 1 is framing error, bit 2 is overrun, bit 3 is break and bit 4 is address byte. Parity, framing and break are captured with `rxWrite`. Overrun is set by `rxOverrun`. Any set flag makes line status pending; it is enabled by `intEnable[2]` and reports code 1.
- R9: With `nineBit`=1, a byte pushed with `rxParity`=1 sets bit 4 (address byte) and not bit 0.
- R10: `lsrRead` clears all line flags. A flag set in the same cycle as the read survives.
- R11: `modemDelta` sets modem pending and `msrRead` clears it; a set wins. This cause is enabled by `intEnable[3]` and reports code 6.
- R12: `irq` is 1 exactly when some enabled cause is pending. `intId` reports the enabled pending cause of highest priority, in this order: line status, data available, time-out, hold empty, transmission complete, modem. It is 0 when none is pending.
- R13: A disabled cause keeps its pending bit. Enabling it later raises `irq` without any new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intEnable | input | 5 | Enables: [0] receive, [1] hold empty, [2] line, [3] modem, [4] transmission complete |
| fifoEn | input | 1 | Receive FIFO mode on |
| nineBit | input | 1 | Nine-bit data mode |
| trigLevel | input | CW | Receive trigger level |
| thrEmpty | input | 1 | Transmit hold register empty level |
| thrWrite | input | 1 | Write strobe to the transmit hold register |
| txShiftDone | input | 1 | Transmit shift register finished a character |
| rxCount | input | CW | Receive FIFO occupancy |
| rxWrite | input | 1 | Received byte pushed into the FIFO |
| rxRead | input | 1 | Receive buffer read (FIFO pop) |
| bitTick | input | 1 | Bit-clock tick |
| rxParity | input | 1 | Parity mismatch of the pushed byte |
| rxFraming | input | 1 | Missing stop bit on the pushed byte |
| rxBreak | input | 1 | Break seen with the pushed byte |
| rxOverrun | input | 1 | Byte lost because the FIFO was full |
| lsrRead | input | 1 | Line status register read strobe |
| modemDelta | input | 1 | Modem input change strobe |
| msrRead | input | 1 | Modem status register read strobe |
| irq | output | 1 | Interrupt request |
| intId | output | 3 | Code of the highest-priority enabled pending cause |
| lineStatus | output | 5 | Sticky line flags |

## Verification
The hardest case to reach from the ports is the receive time-out. It needs forty uninterrupted tick cycles while the count stays strictly between zero and the trigger, with no push or pop in between. Random traffic rarely produces that. Directed runs hold `bitTick` high with the access strobes quiet, and they check both the cycle one tick short of the limit and the cycle at the limit. A pop partway through a run shows that the count restarts. The random phase keeps access rates low, so some time-outs also occur there, and these are then cleared by draining the FIFO.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Cause indices, lowest index has highest priority; id code = index + 1.
  localparam int NUM_SRC    = 6;
  localparam int SRC_LINE   = 0;
  localparam int SRC_RXRDY  = 1;
  localparam int SRC_RXTO   = 2;
  localparam int SRC_THRE   = 3;
  localparam int SRC_TXDONE = 4;
  localparam int SRC_MODEM  = 5;

  // Enable vector bit positions.
  localparam int NUM_EN    = 5;
  localparam int EN_RX     = 0;
  localparam int EN_THRE   = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;
  localparam int EN_TXDONE = 4;

  // Line flag bit positions.
  localparam int NUM_LINE = 5;
  localparam int LF_PAR   = 0;
  localparam int LF_FRM   = 1;
  localparam int LF_OVR   = 2;
  localparam int LF_BRK   = 3;
  localparam int LF_ADDR  = 4;

  typedef enum logic [2:0] {
    ID_NONE   = 3'd0,
    ID_LINE   = 3'd1,
    ID_RXRDY  = 3'd2,
    ID_RXTO   = 3'd3,
    ID_THRE   = 3'd4,
    ID_TXDONE = 3'd5,
    ID_MODEM  = 3'd6
  } irq_id_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                threSet;
    logic                txClr;
    logic                doneSet;
    logic                rdyLevel;
    logic                toRestart;
    logic                toTick;
    logic                toEmpty;
    logic [NUM_LINE-1:0] lineSet;
    logic                lineClr;
    logic                msSet;
    logic                msClr;
  } irq_strobe_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EN-1:0]  intEnable,
  input  logic               fifoEn,
  input  logic               nineBit,
  input  logic [CW-1:0]      trigLevel,
  input  logic               thrEmpty,
  input  logic               thrWrite,
  input  logic               txShiftDone,
  input  logic [CW-1:0]      rxCount,
  input  logic               rxWrite,
  input  logic               rxRead,
  input  logic               bitTick,
  input  logic               rxParity,
  input  logic               rxFraming,
  input  logic               rxBreak,
  input  logic               rxOverrun,
  input  logic               lsrRead,
  input  logic               modemDelta,
  input  logic               msrRead,
  input  logic [NUM_SRC-1:0] pendVec,
  output irq_strobe_t        strb,
  output logic               irq,
  output logic [2:0]         intId
);

  logic prevEmpty;
  logic rxAccess;
  logic toArmed;
  logic notEmpty;
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] live;

  // Edge detect on the hold-register-empty level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEmpty <= 1'b0;
    else       prevEmpty <= thrEmpty;
  end

  always_comb begin
    notEmpty = (rxCount != '0);
    rxAccess = rxRead | rxWrite;
    toArmed  = fifoEn & notEmpty & (rxCount < trigLevel);

    strb           = '0;
    strb.threSet   = thrEmpty & ~prevEmpty;
    strb.txClr     = thrWrite;
    strb.doneSet   = txShiftDone;
    strb.rdyLevel  = fifoEn ? (notEmpty & (rxCount >= trigLevel)) : notEmpty;
    strb.toRestart = ~toArmed | rxAccess;
    strb.toTick    = bitTick;
    strb.toEmpty   = ~notEmpty;
    strb.lineSet[LF_PAR]  = rxWrite & rxParity & ~nineBit;
    strb.lineSet[LF_ADDR] = rxWrite & rxParity & nineBit;
    strb.lineSet[LF_FRM]  = rxWrite & rxFraming;
    strb.lineSet[LF_BRK]  = rxWrite & rxBreak;
    strb.lineSet[LF_OVR]  = rxOverrun;
    strb.lineClr   = lsrRead;
    strb.msSet     = modemDelta;
    strb.msClr     = msrRead;
  end

  // Expand the enable vector onto the cause vector.
  always_comb begin
    srcEn             = '0;
    srcEn[SRC_LINE]   = intEnable[EN_LINE];
    srcEn[SRC_RXRDY]  = intEnable[EN_RX];
    srcEn[SRC_RXTO]   = intEnable[EN_RX];
    srcEn[SRC_THRE]   = intEnable[EN_THRE];
    srcEn[SRC_TXDONE] = intEnable[EN_TXDONE];
    srcEn[SRC_MODEM]  = intEnable[EN_MODEM];
  end

  assign live = pendVec & srcEn;
  assign irq  = |live;

  // Priority encode: scanning downward, the lowest set index remains.
  always_comb begin
    intId = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) intId = 3'(i + 1);
    end
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CHAR_TICKS = 10,
  parameter int TO_CHARS   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  irq_strobe_t         strb,
  output logic [NUM_SRC-1:0]  pendVec,
  output logic [NUM_LINE-1:0] lineStatus
);

  localparam int TO_TICKS = CHAR_TICKS * TO_CHARS;
  localparam int TW       = $clog2(TO_TICKS + 1);

  logic [TW-1:0] toCnt;
  logic          toHit;
  logic          rdyPend;
  logic          toPend;
  logic          threPend;
  logic          donePend;
  logic          msPend;
  logic [NUM_LINE-1:0] lineFlag;

  assign toHit = ~strb.toRestart & strb.toTick & (toCnt == TW'(TO_TICKS - 1));

  // Silence counter in bit ticks, saturating at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       toCnt <= '0;
    else if (strb.toRestart)                         toCnt <= '0;
    else if (strb.toTick && toCnt != TW'(TO_TICKS))  toCnt <= toCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyPend  <= 1'b0;
      toPend   <= 1'b0;
      threPend <= 1'b0;
      donePend <= 1'b0;
      msPend   <= 1'b0;
    end else begin
      rdyPend <= strb.rdyLevel;

      if (strb.toEmpty)  toPend <= 1'b0;
      else if (toHit)    toPend <= 1'b1;

      if (strb.txClr)        threPend <= 1'b0;
      else if (strb.threSet) threPend <= 1'b1;

      if (strb.txClr)        donePend <= 1'b0;
      else if (strb.doneSet) donePend <= 1'b1;

      if (strb.msSet)        msPend <= 1'b1;
      else if (strb.msClr)   msPend <= 1'b0;
    end
  end

  // Sticky line flags: a new event beats the clearing read.
  for (genvar g = 0; g < NUM_LINE; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 lineFlag[g] <= 1'b0;
      else if (strb.lineSet[g])  lineFlag[g] <= 1'b1;
      else if (strb.lineClr)     lineFlag[g] <= 1'b0;
    end
  end

  always_comb begin
    pendVec             = '0;
    pendVec[SRC_LINE]   = |lineFlag;
    pendVec[SRC_RXRDY]  = rdyPend;
    pendVec[SRC_RXTO]   = toPend;
    pendVec[SRC_THRE]   = threPend;
    pendVec[SRC_TXDONE] = donePend;
    pendVec[SRC_MODEM]  = msPend;
  end

  assign lineStatus = lineFlag;

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CHAR_TICKS = 10,
  parameter int TO_CHARS   = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [4:0]    intEnable,
  input  logic          fifoEn,
  input  logic          nineBit,
  input  logic [CW-1:0] trigLevel,
  input  logic          thrEmpty,
  input  logic          thrWrite,
  input  logic          txShiftDone,
  input  logic [CW-1:0] rxCount,
  input  logic          rxWrite,
  input  logic          rxRead,
  input  logic          bitTick,
  input  logic          rxParity,
  input  logic          rxFraming,
  input  logic          rxBreak,
  input  logic          rxOverrun,
  input  logic          lsrRead,
  input  logic          modemDelta,
  input  logic          msrRead,
  output logic          irq,
  output logic [2:0]    intId,
  output logic [4:0]    lineStatus
);

  irq_strobe_t        strb;
  logic [NUM_SRC-1:0] pendVec;

  uart_irq_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .intEnable   (intEnable),
    .fifoEn      (fifoEn),
    .nineBit     (nineBit),
    .trigLevel   (trigLevel),
    .thrEmpty    (thrEmpty),
    .thrWrite    (thrWrite),
    .txShiftDone (txShiftDone),
    .rxCount     (rxCount),
    .rxWrite     (rxWrite),
    .rxRead      (rxRead),
    .bitTick     (bitTick),
    .rxParity    (rxParity),
    .rxFraming   (rxFraming),
    .rxBreak     (rxBreak),
    .rxOverrun   (rxOverrun),
    .lsrRead     (lsrRead),
    .modemDelta  (modemDelta),
    .msrRead     (msrRead),
    .pendVec     (pendVec),
    .strb        (strb),
    .irq         (irq),
    .intId       (intId)
  );

  uart_irq_dp #(.CHAR_TICKS(CHAR_TICKS), .TO_CHARS(TO_CHARS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pendVec    (pendVec),
    .lineStatus (lineStatus)
  );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [4:0]         intEnable,
  input logic               fifoEn,
  input logic               thrWrite,
  input logic [CW-1:0]      rxCount,
  input logic               rxWrite,
  input logic               rxOverrun,
  input logic               lsrRead,
  input logic               modemDelta,
  input logic [NUM_SRC-1:0] pendVec,
  input logic               irq,
  input logic [2:0]         intId,
  input logic [4:0]         lineStatus
);

  // R3: a hold-register write leaves no transmit cause pending.
  a_r3_write_clears_tx: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> (!pendVec[SRC_THRE] && !pendVec[SRC_TXDONE]));

  // R5: a time-out can only arise in FIFO mode.
  a_r5_timeout_fifo_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendVec[SRC_RXTO]) |-> $past(fifoEn));

  // R6: a raised time-out persists while data remains.
  a_r6_timeout_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[SRC_RXTO] && rxCount != '0) |=> pendVec[SRC_RXTO]);

  // R6: an empty FIFO drops the time-out.
  a_r6_timeout_drops: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |=> !pendVec[SRC_RXTO]);

  // R10: a read with no new event clears every line flag.
  a_r10_lsr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !rxWrite && !rxOverrun) |=> (lineStatus == '0));

  // R11: a modem change is always recorded.
  a_r11_modem_set: assert property (@(posedge clk) disable iff (!rstN)
    modemDelta |=> pendVec[SRC_MODEM]);

  // R12: request line and identification code agree.
  a_r12_irq_id_agree: assert property (@(posedge clk) disable iff (!rstN)
    irq == (intId != ID_NONE));

  // R12: an enabled line cause always wins.
  a_r12_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[SRC_LINE] && intEnable[EN_LINE]) |-> (intId == ID_LINE));

endmodule

bind uart_irq_unit uart_irq_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .intEnable  (intEnable),
  .fifoEn     (fifoEn),
  .thrWrite   (thrWrite),
  .rxCount    (rxCount),
  .rxWrite    (rxWrite),
  .rxOverrun  (rxOverrun),
  .lsrRead    (lsrRead),
  .modemDelta (modemDelta),
  .pendVec    (pendVec),
  .irq        (irq),
  .intId      (intId),
  .lineStatus (lineStatus)
);

// File: tb/uart_irq_unit_bench.sv
`timescale 1ns/1ps
module uart_irq_unit_bench;

  localparam int TO_TICKS = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] intEnable = '0;
  logic       fifoEn = 1'b0, nineBit = 1'b0;
  logic [4:0] trigLevel = 5'd4;
  logic       thrEmpty = 1'b0, thrWrite = 1'b0, txShiftDone = 1'b0;
  logic [4:0] rxCount = '0;
  logic       rxWrite = 1'b0, rxRead = 1'b0, bitTick = 1'b0;
  logic       rxParity = 1'b0, rxFraming = 1'b0, rxBreak = 1'b0, rxOverrun = 1'b0;
  logic       lsrRead = 1'b0, modemDelta = 1'b0, msrRead = 1'b0;
  logic       irq;
  logic [2:0] intId;
  logic [4:0] lineStatus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic mThre = 0, mDone = 0, mRdy = 0, mTo = 0, mMs = 0, mPrev = 0;
  logic [4:0] mLine = '0;
  int mCnt = 0;

  always #2 clk = ~clk;

  uart_irq_unit u_uart_irq_unit (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .fifoEn(fifoEn), .nineBit(nineBit),
    .trigLevel(trigLevel), .thrEmpty(thrEmpty), .thrWrite(thrWrite), .txShiftDone(txShiftDone),
    .rxCount(rxCount), .rxWrite(rxWrite), .rxRead(rxRead), .bitTick(bitTick),
    .rxParity(rxParity), .rxFraming(rxFraming), .rxBreak(rxBreak), .rxOverrun(rxOverrun),
    .lsrRead(lsrRead), .modemDelta(modemDelta), .msrRead(msrRead),
    .irq(irq), .intId(intId), .lineStatus(lineStatus)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] expLive();
    return {mMs & intEnable[3], mDone & intEnable[4], mThre & intEnable[1],
            mTo & intEnable[0], mRdy & intEnable[0], (|mLine) & intEnable[2]};
  endfunction

  function automatic logic [2:0] expId();
    logic [5:0] p;
    logic [2:0] id;
    p = expLive();
    id = 3'd0;
    for (int i = 5; i >= 0; i--) if (p[i]) id = 3'(i + 1);
    return id;
  endfunction

  // Advance one cycle: update the reference from the driven inputs,
  // pass the edge, compare at the falling edge, then drop strobes.
  task automatic step();
    logic armed, hit;
    logic [4:0] newL;
    armed = fifoEn && rxCount != 0 && rxCount < trigLevel;
    hit = armed && !(rxRead || rxWrite) && bitTick && mCnt == TO_TICKS - 1;
    if (rxCount == 0) mTo = 0; else if (hit) mTo = 1;
    if (!armed || rxRead || rxWrite) mCnt = 0;
    else if (bitTick && mCnt != TO_TICKS) mCnt++;
    mRdy = fifoEn ? (rxCount != 0 && rxCount >= trigLevel) : (rxCount != 0);
    if (thrWrite) mThre = 0; else if (thrEmpty && !mPrev) mThre = 1;
    mPrev = thrEmpty;
    if (thrWrite) mDone = 0; else if (txShiftDone) mDone = 1;
    newL = {nineBit & rxWrite & rxParity, rxWrite & rxBreak, rxOverrun,
            rxWrite & rxFraming, ~nineBit & rxWrite & rxParity};
    mLine = (lsrRead ? 5'b0 : mLine) | newL;
    if (modemDelta) mMs = 1; else if (msrRead) mMs = 0;
    @(posedge clk);
    @(negedge clk);
    chk(intId == expId(), "R12 id", intId, expId());
    chk(irq == (|expLive()), "R12 irq", irq, |expLive());
    chk(lineStatus == mLine, "R8 flags", lineStatus, mLine);
    thrWrite = 0; txShiftDone = 0; rxWrite = 0; rxRead = 0;
    rxParity = 0; rxFraming = 0; rxBreak = 0; rxOverrun = 0;
    lsrRead = 0; modemDelta = 0; msrRead = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(intId == 3'd0, "R1 id", intId, 0);
    chk(lineStatus == 5'd0, "R1 flags", lineStatus, 0);
    rstN = 1;
    intEnable = 5'b11111;
    step();
    chk(irq == 1'b0, "R1 after release", irq, 0);

    // R2 hold empty edge
    thrEmpty = 1; step();
    chk(intId == 3'd4, "R2", intId, 4);
    // R3 write clears, done strobe, write wins
    thrWrite = 1; thrEmpty = 0; step();
    chk(intId == 3'd0, "R3 clear", intId, 0);
    txShiftDone = 1; step();
    chk(intId == 3'd5, "R3 done", intId, 5);
    txShiftDone = 1; thrWrite = 1; step();
    chk(intId == 3'd0, "R3 write wins", intId, 0);

    // R4 data available
    fifoEn = 0; rxCount = 1; step();
    chk(intId == 3'd2, "R4 no fifo", intId, 2);
    rxCount = 0; step();
    chk(intId == 3'd0, "R4 empty", intId, 0);
    fifoEn = 1; trigLevel = 4; rxCount = 3; step();
    chk(intId == 3'd0, "R4 below trigger", intId, 0);
    rxCount = 4; step();
    chk(intId == 3'd2, "R4 at trigger", intId, 2);

    // R5 time-out limit
    rxCount = 2; rxWrite = 1; step();
    bitTick = 1;
    for (int i = 0; i < TO_TICKS - 1; i++) step();
    chk(intId == 3'd0, "R5 one tick short", intId, 0);
    step();
    chk(intId == 3'd3, "R5 limit", intId, 3);
    // R6 persistence
    rxRead = 1; rxCount = 1; step();
    chk(intId == 3'd3, "R6 after pop", intId, 3);
    rxCount = 5; step();
    chk(intId == 3'd2, "R6 above trigger", intId, 2);
    rxCount = 1; step();
    chk(intId == 3'd3, "R6 still held", intId, 3);
    rxCount = 0; step();
    chk(intId == 3'd0, "R6 emptied", intId, 0);

    // R7 access restarts the count
    rxCount = 1; rxWrite = 1; step();
    for (int i = 0; i < 30; i++) step();
    rxRead = 1; step();
    for (int i = 0; i < TO_TICKS - 1; i++) step();
    chk(intId == 3'd0, "R7 restarted", intId, 0);
    step();
    chk(intId == 3'd3, "R7 full window", intId, 3);
    rxCount = 0; bitTick = 0; step();

    // R8 line flags
    rxWrite = 1; rxFraming = 1; rxBreak = 1; step();
    chk(lineStatus == 5'b01010, "R8 frm brk", lineStatus, 5'b01010);
    chk(intId == 3'd1, "R8 id", intId, 1);
    rxOverrun = 1; step();
    chk(lineStatus == 5'b01110, "R8 overrun", lineStatus, 5'b01110);
    // R10 clear and simultaneous set
    lsrRead = 1; step();
    chk(lineStatus == 5'b0, "R10 clear", lineStatus, 0);
    lsrRead = 1; rxWrite = 1; rxParity = 1; step();
    chk(lineStatus == 5'b00001, "R10 set survives", lineStatus, 1);
    lsrRead = 1; step();
    // R9 nine-bit address
    nineBit = 1; rxWrite = 1; rxParity = 1; step();
    chk(lineStatus == 5'b10000, "R9 address", lineStatus, 5'b10000);
    chk(intId == 3'd1, "R9 id", intId, 1);
    lsrRead = 1; nineBit = 0; step();

    // R11 modem
    modemDelta = 1; step();
    chk(intId == 3'd6, "R11 set", intId, 6);
    msrRead = 1; step();
    chk(intId == 3'd0, "R11 clear", intId, 0);
    modemDelta = 1; msrRead = 1; step();
    chk(intId == 3'd6, "R11 set wins", intId, 6);
    msrRead = 1; step();

    // R12 priority walk
    thrEmpty = 1; modemDelta = 1; txShiftDone = 1; rxWrite = 1; rxFraming = 1;
    fifoEn = 0; rxCount = 1; step();
    chk(intId == 3'd1, "R12 line first", intId, 1);
    lsrRead = 1; step();
    chk(intId == 3'd2, "R12 data next", intId, 2);
    rxRead = 1; rxCount = 0; step();
    chk(intId == 3'd4, "R12 hold empty", intId, 4);
    thrWrite = 1; thrEmpty = 0; step();
    chk(intId == 3'd6, "R12 modem last", intId, 6);
    msrRead = 1; fifoEn = 1; step();

    // R13 disabled stays pending
    intEnable = 5'b00000; modemDelta = 1; step();
    chk(irq == 1'b0, "R13 masked", irq, 0);
    intEnable = 5'b01000; step();
    chk(irq == 1'b1 && intId == 3'd6, "R13 enable later", {irq, intId}, {1'b1, 3'd6});
    msrRead = 1; intEnable = 5'b11111; step();

    // Random phase
    cnt = 0;
    for (int n = 0; n < 3000; n++) begin
      int r;
      bitTick = (($urandom % 10) < 7);
      if ($urandom % 50 == 0) thrEmpty = ~thrEmpty;
      thrWrite = ($urandom % 40 == 0);
      if (thrWrite) thrEmpty = 0;
      txShiftDone = ($urandom % 40 == 0);
      r = $urandom % 100;
      if (r < 3 && cnt < 16) begin
        rxWrite = 1; cnt++;
        rxParity = ($urandom % 4 == 0);
        rxFraming = ($urandom % 6 == 0);
        rxBreak = ($urandom % 8 == 0);
      end else if (r < 5 && cnt > 0) begin
        rxRead = 1; cnt--;
      end
      rxOverrun = ($urandom % 60 == 0);
      lsrRead = ($urandom % 30 == 0);
      modemDelta = ($urandom % 60 == 0);
      msrRead = ($urandom % 30 == 0);
      if ($urandom % 500 == 0) trigLevel = 5'(1 + $urandom % 8);
      if ($urandom % 700 == 0) fifoEn = ~fifoEn;
      if ($urandom % 400 == 0) nineBit = ~nineBit;
      if ($urandom % 200 == 0) intEnable = 5'($urandom);
      rxCount = 5'(cnt);
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule